// File: doc/BRIEF.md
# Keyboard-Controller-Style Host Register Window

This block gives a host bus master a two-port, byte-wide register window into a management controller. The host sees a data port at a programmable base address and a command/status port one address above it. A host write to either port lands in an input data register. The written port is recorded as a command/data flag. A host read of the data port returns the output data register. A host read of the command/status port returns an 8-bit status byte.

The local management side reads the input register and writes the output register. It also loads the 2-bit interface state and sets or clears an attention flag. Two handshake flags track whether a byte is waiting in each direction: input-full for host-to-local and output-full for local-to-host. Both flags set and clear as side effects of the accesses of both parties. The channel only responds when it is enabled. A separately enabled interrupt tells the local side that an input byte is waiting. The host bus uses a plain strobe interface with one-cycle read and write pulses.

Top module: `kcs_host_window`

## Requirements
- R1: After reset the status byte is 0xC0: state 3 (error), with the command/data flag, attention, input-full and output-full all 0. The interrupt is low.
- R2: With the channel enabled, the data port is at `cfg_base` and the command/status port is at `cfg_base + 1`, wrapping modulo 2^ADDR_W. A host access to any other address changes no flag or register, and its read data is 0.
- R3: A host write to either port loads the byte into the input register, which appears on `bmc_idr` in the next cycle. The command/data flag (status bit 3) becomes 1 for the command/status port and 0 for the data port.
- R4: A host write to either port sets input-full (status bit 1) in the next cycle.
- R5: A local read strobe `bmc_idr_rd` clears input-full in the next cycle. If a host write lands in the same cycle, input-full stays 1.
- R6: A local write `bmc_odr_wr` loads the output register and sets output-full (status bit 0) in the next cycle. A host read of the data port returns the output register in the same cycle.
- R7: A host read of the data port clears output-full in the next cycle, unless a local write lands in the same cycle, in which case output-full stays 1. A host read of the command/status port has no side effect.
- R8: The status byte is {state[1:0], 2'b00, command/data, attention, input-full, output-full}. It is returned by a host read of the command/status port and is always visible on `bmc_status`. With `host_rd` low, `host_rdata` is 0.
- R9: `bmc_state_wr` loads the state field (bits 7:6) in the next cycle. The codes are 0 idle, 1 read, 2 write and 3 error.
- R10: The attention flag (bit 2) is set by `bmc_atn_set` and cleared by `bmc_atn_clr`. Set wins when both are asserted. Host accesses never change it.
- R11: With `cfg_enable` low, host writes change nothing and host reads return 0 with no side effect.
- R12: `bmc_irq` is high exactly when input-full is 1 and both `cfg_enable` and `cfg_irq_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Channel enable |
| cfg_irq_en | input | 1 | Input-full interrupt enable |
| cfg_base | input | ADDR_W | Data port address; the command/status port is one above it |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, same cycle as `host_rd` |
| bmc_idr_rd | input | 1 | Local read of the input register; clears input-full |
| bmc_idr | output | 8 | Input data register |
| bmc_odr_wr | input | 1 | Local write of the output register |
| bmc_odr_wdata | input | 8 | Output register write data |
| bmc_state_wr | input | 1 | Load state field |
| bmc_state_val | input | 2 | New state code |
| bmc_atn_set | input | 1 | Set attention flag |
| bmc_atn_clr | input | 1 | Clear attention flag |
| bmc_status | output | 8 | Status byte as the host sees it |
| bmc_irq | output | 1 | Input-full interrupt |

## Verification
All internal state is visible at the ports: the flags, the state field and the attention bit appear in `bmc_status` one cycle after the access that changed them. The stored bytes appear directly on `bmc_idr` and through a data port read. A wrong flag update, such as a lost set-priority when both parties access in the same cycle, shows on the status byte in the very next cycle. It also shows on `bmc_irq` in that same cycle. A decode fault shows as a flag that changes after an access to an address that should miss, or as nonzero read data on such an access. The bench keeps a reference copy of every field, checks it after each random or directed cycle, and checks the read data in the cycle of each host read.

// File: rtl/kcs_pkg.sv
// Shared types and status bit positions for the host register window.
// Assumes byte-wide ports; the status layout is fixed by the host protocol.
package kcs_pkg;
    localparam int BYTE_W = 8;

    // Interface state codes seen by the host in status bits 7:6.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_ERROR = 2'd3
    } kcs_state_e;

    localparam int SB_OBF   = 0;
    localparam int SB_IBF   = 1;
    localparam int SB_ATN   = 2;
    localparam int SB_CD    = 3;
    localparam int SB_ST_LO = 6;
endpackage

// File: rtl/kcs_addr_match.sv
// Address decode for the two host ports.
// Assumes the command/status port is at base + 1 and wraps modulo 2^ADDR_W.
// When the channel is disabled, no access hits.
module kcs_addr_match #(
    parameter int ADDR_W = 16
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              sel_data,
    output logic              sel_cmd,
    output logic              wr_hit,
    output logic              data_rd,
    output logic              cmd_rd
);
    logic [ADDR_W-1:0] cmd_addr;

    // Compare the host address with both port addresses.
    always_comb begin
        cmd_addr = base + {{(ADDR_W-1){1'b0}}, 1'b1};
        sel_data = enable && (addr == base);
        sel_cmd  = enable && (addr == cmd_addr);
        wr_hit   = wr && (sel_data || sel_cmd);
        data_rd  = rd && sel_data;
        cmd_rd   = rd && sel_cmd;
    end
endmodule

// File: rtl/kcs_flag_regs.sv
// Data registers and handshake flags of the window.
// Assumes single-cycle strobes. A host write beats a same-cycle local read
// for input-full, and a local write beats a same-cycle host data read for
// output-full.
module kcs_flag_regs
    import kcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              is_cmd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              idr_rd,
    input  logic              odr_wr,
    input  logic [BYTE_W-1:0] odr_wdata,
    input  logic              data_rd,
    output logic [BYTE_W-1:0] idr,
    output logic [BYTE_W-1:0] odr,
    output logic              ibf,
    output logic              obf,
    output logic              cd
);
    // Host-to-local path: input register, command/data flag, input-full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idr <= '0;
            ibf <= 1'b0;
            cd  <= 1'b0;
        end else if (wr_hit) begin
            idr <= wdata;
            ibf <= 1'b1;
            cd  <= is_cmd;
        end else if (idr_rd) begin
            ibf <= 1'b0;
        end
    end

    // Local-to-host path: output register and output-full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odr <= '0;
            obf <= 1'b0;
        end else if (odr_wr) begin
            odr <= odr_wdata;
            obf <= 1'b1;
        end else if (data_rd) begin
            obf <= 1'b0;
        end
    end

    a_r4_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ibf);
    a_r3_cd_port: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cd == $past(is_cmd)) && (idr == $past(wdata)));
    a_r5_ibf_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (idr_rd && !wr_hit) |=> !ibf);
    a_r6_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
        odr_wr |=> obf && (odr == $past(odr_wdata)));
    a_r7_obf_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !odr_wr) |=> !obf);
    a_r7_odr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !odr_wr |=> $stable(odr));
endmodule

// File: rtl/kcs_status_ctl.sv
// Locally owned status fields: interface state and attention flag.
// Assumes reset puts the state at error so the host can see the reset.
// Set beats clear on the attention flag.
module kcs_status_ctl
    import kcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       state_wr,
    input  logic [1:0] state_val,
    input  logic       atn_set,
    input  logic       atn_clr,
    output kcs_state_e state,
    output logic       atn
);
    // Load the interface state on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= ST_ERROR;
        else if (state_wr) state <= kcs_state_e'(state_val);
    end

    // Set or clear the attention flag; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       atn <= 1'b0;
        else if (atn_set) atn <= 1'b1;
        else if (atn_clr) atn <= 1'b0;
    end

    a_r9_state_load: assert property (@(posedge clk) disable iff (!rst_n)
        state_wr |=> state == $past(state_val));
    a_r9_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !state_wr |=> $stable(state));
    a_r10_atn_set: assert property (@(posedge clk) disable iff (!rst_n)
        atn_set |=> atn);
    a_r10_atn_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (atn_clr && !atn_set) |=> !atn);
endmodule

// File: rtl/kcs_host_window.sv
// Top of the keyboard-controller-style host register window.
// Assumes one-cycle host strobes. Read data is combinational in the strobe
// cycle, and every register side effect lands at the next clock edge.
module kcs_host_window
    import kcs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_irq_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              bmc_idr_rd,
    output logic [BYTE_W-1:0] bmc_idr,
    input  logic              bmc_odr_wr,
    input  logic [BYTE_W-1:0] bmc_odr_wdata,
    input  logic              bmc_state_wr,
    input  logic [1:0]        bmc_state_val,
    input  logic              bmc_atn_set,
    input  logic              bmc_atn_clr,
    output logic [BYTE_W-1:0] bmc_status,
    output logic              bmc_irq
);
    logic              sel_data, sel_cmd, wr_hit, data_rd, cmd_rd;
    logic [BYTE_W-1:0] odr;
    logic              ibf, obf, cd, atn;
    kcs_state_e        state;

    kcs_addr_match #(.ADDR_W(ADDR_W)) u_dec (
        .enable   (cfg_enable),
        .base     (cfg_base),
        .addr     (host_addr),
        .wr       (host_wr),
        .rd       (host_rd),
        .sel_data (sel_data),
        .sel_cmd  (sel_cmd),
        .wr_hit   (wr_hit),
        .data_rd  (data_rd),
        .cmd_rd   (cmd_rd)
    );

    kcs_flag_regs u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .is_cmd    (sel_cmd),
        .wdata     (host_wdata),
        .idr_rd    (bmc_idr_rd),
        .odr_wr    (bmc_odr_wr),
        .odr_wdata (bmc_odr_wdata),
        .data_rd   (data_rd),
        .idr       (bmc_idr),
        .odr       (odr),
        .ibf       (ibf),
        .obf       (obf),
        .cd        (cd)
    );

    kcs_status_ctl u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_wr  (bmc_state_wr),
        .state_val (bmc_state_val),
        .atn_set   (bmc_atn_set),
        .atn_clr   (bmc_atn_clr),
        .state     (state),
        .atn       (atn)
    );

    // Assemble the status byte from the individual fields.
    always_comb begin
        bmc_status                        = '0;
        bmc_status[SB_ST_LO+1:SB_ST_LO]   = state;
        bmc_status[SB_CD]                 = cd;
        bmc_status[SB_ATN]                = atn;
        bmc_status[SB_IBF]                = ibf;
        bmc_status[SB_OBF]                = obf;
    end

    // Steer the host read data and drive the interrupt.
    always_comb begin
        if (data_rd)     host_rdata = odr;
        else if (cmd_rd) host_rdata = bmc_status;
        else             host_rdata = '0;
        bmc_irq = ibf && cfg_enable && cfg_irq_en;
    end

    a_r11_dis_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !bmc_idr_rd) |=> $stable(ibf));
    a_r12_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        bmc_irq |-> bmc_status[SB_IBF]);
    a_r7_stat_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !bmc_odr_wr) |=> $stable(obf));
    a_r1_reset_err: assert property (@(posedge clk)
        !rst_n |=> state == ST_ERROR);
endmodule

// File: tb/sim_kcs_host_window.sv
module sim_kcs_host_window;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0, cfg_irq_en = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          bmc_idr_rd = 1'b0;
    logic [7:0]    bmc_idr;
    logic          bmc_odr_wr = 1'b0;
    logic [7:0]    bmc_odr_wdata = '0;
    logic          bmc_state_wr = 1'b0;
    logic [1:0]    bmc_state_val = '0;
    logic          bmc_atn_set = 1'b0, bmc_atn_clr = 1'b0;
    logic [7:0]    bmc_status;
    logic          bmc_irq;

    int total = 0;
    int bad = 0;

    // Reference copy of the register fields.
    logic [7:0] m_idr = 0, m_odr = 0;
    logic       m_ibf = 0, m_obf = 0, m_cd = 0, m_atn = 0;
    logic [1:0] m_state = 2'd3;

    always #4 clk = ~clk;

    kcs_host_window #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_irq_en(cfg_irq_en),
        .cfg_base(cfg_base), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .bmc_idr_rd(bmc_idr_rd), .bmc_idr(bmc_idr), .bmc_odr_wr(bmc_odr_wr),
        .bmc_odr_wdata(bmc_odr_wdata), .bmc_state_wr(bmc_state_wr),
        .bmc_state_val(bmc_state_val), .bmc_atn_set(bmc_atn_set),
        .bmc_atn_clr(bmc_atn_clr), .bmc_status(bmc_status), .bmc_irq(bmc_irq)
    );

    function automatic logic [7:0] exp_status();
        return {m_state, 2'b00, m_cd, m_atn, m_ibf, m_obf};
    endfunction

    function automatic logic hit_d(logic [AW-1:0] a);
        return cfg_enable && (a == cfg_base);
    endfunction

    function automatic logic hit_c(logic [AW-1:0] a);
        return cfg_enable && (a == cfg_base + 16'd1);
    endfunction

    function automatic logic [7:0] exp_rdata(logic [AW-1:0] a);
        if (hit_d(a)) return m_odr;
        if (hit_c(a)) return exp_status();
        return 8'h00;
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: inputs are set at the falling edge, read data is checked
    // before the rising edge, and the registered fields after it.
    task automatic drive(string tag, logic wr, logic rd, logic [AW-1:0] a,
                         logic [7:0] wd, logic irr, logic ow, logic [7:0] od,
                         logic sw, logic [1:0] sv, logic as, logic ac);
        logic hd, hc;
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
        bmc_idr_rd = irr; bmc_odr_wr = ow; bmc_odr_wdata = od;
        bmc_state_wr = sw; bmc_state_val = sv; bmc_atn_set = as; bmc_atn_clr = ac;
        #1;
        check(tag, "host_rdata", host_rdata, rd ? exp_rdata(a) : 8'h00);
        hd = hit_d(a); hc = hit_c(a);
        @(posedge clk);
        if (wr && (hd || hc)) begin m_idr = wd; m_ibf = 1; m_cd = hc; end
        else if (irr) m_ibf = 0;
        if (ow) begin m_odr = od; m_obf = 1; end
        else if (rd && hd) m_obf = 0;
        if (sw) m_state = sv;
        if (as) m_atn = 1; else if (ac) m_atn = 0;
        @(negedge clk);
        check(tag, "status", bmc_status, exp_status());
        check(tag, "idr", bmc_idr, m_idr);
        check(tag, "irq", {7'd0, bmc_irq}, {7'd0, m_ibf & cfg_enable & cfg_irq_en});
        host_wr = 0; host_rd = 0; bmc_idr_rd = 0; bmc_odr_wr = 0;
        bmc_state_wr = 0; bmc_atn_set = 0; bmc_atn_clr = 0;
    endtask

    task automatic idle(string tag);
        drive(tag, 0, 0, '0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        void'($urandom(32'h0000_4b43));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("R1", "status", bmc_status, 8'hC0);
        check("R1", "irq", {7'd0, bmc_irq}, 8'h00);

        cfg_enable = 1; cfg_irq_en = 1; base = 16'h0CA2; cfg_base = base;
        // R3 R4 R12: data port write
        drive("R4", 1, 0, base, 8'h11, 0, 0, 0, 0, 0, 0, 0);
        // R3: command port write sets command/data
        drive("R3", 1, 0, base + 1, 8'h61, 0, 0, 0, 0, 0, 0, 0);
        // R5: write wins over same-cycle local read, then local read clears
        drive("R5", 1, 0, base, 8'h22, 1, 0, 0, 0, 0, 0, 0);
        drive("R5", 0, 0, base, 8'h00, 1, 0, 0, 0, 0, 0, 0);
        // R6: local write, host data read returns it; R7 read clears output-full
        drive("R6", 0, 0, base, 0, 0, 1, 8'hA5, 0, 0, 0, 0);
        drive("R7", 0, 1, base + 1, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R6", 0, 1, base, 0, 0, 0, 0, 0, 0, 0, 0);
        // R7: local write wins over same-cycle host read
        drive("R7", 0, 1, base, 0, 0, 1, 8'h3C, 0, 0, 0, 0);
        // R9: every state code
        for (int s = 0; s < 4; s++) drive("R9", 0, 0, 0, 0, 0, 0, 0, 1, s[1:0], 0, 0);
        // R8: status read reflects all fields
        drive("R8", 0, 1, base + 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10: set, host write leaves it, set+clear keeps set, clear
        drive("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
        drive("R10", 1, 0, base + 1, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        drive("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        drive("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        // R12: interrupt enable gating
        cfg_irq_en = 0;
        drive("R12", 1, 0, base, 8'h44, 0, 0, 0, 0, 0, 0, 0);
        cfg_irq_en = 1;
        idle("R12");
        // R11: disabled channel ignores host accesses
        drive("R11", 0, 0, 0, 0, 1, 1, 8'h77, 0, 0, 0, 0);
        cfg_enable = 0;
        drive("R11", 1, 0, base, 8'h99, 0, 0, 0, 0, 0, 0, 0);
        drive("R11", 0, 1, base, 0, 0, 0, 0, 0, 0, 0, 0);
        drive("R11", 0, 1, base + 1, 0, 0, 0, 0, 0, 0, 0, 0);
        cfg_enable = 1;
        // R2: wrap of command port, misses ignored
        base = 16'hFFFF; cfg_base = base;
        drive("R2", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        drive("R2", 1, 0, 16'h0000, 8'h5A, 0, 0, 0, 0, 0, 0, 0);
        drive("R2", 1, 0, 16'hFFFE, 8'h6B, 1, 0, 0, 0, 0, 0, 0);
        drive("R2", 0, 1, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0);

        // Random mix around a fixed base.
        base = 16'h0CA2; cfg_base = base;
        for (int i = 0; i < 800; i++) begin
            logic [AW-1:0] a;
            int sel;
            sel = $urandom_range(0, 5);
            a = (sel < 2) ? base : (sel < 4) ? base + 1 : (sel == 4) ? base + 2 : base - 1;
            cfg_enable = ($urandom_range(0, 15) != 0);
            cfg_irq_en = ($urandom_range(0, 3) != 0);
            drive("R8", $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, a,
                  8'($urandom), $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                  8'($urandom), $urandom_range(0, 5) == 0, 2'($urandom),
                  $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule